// File: doc/BRIEF.md
# Non-Maskable Fault Interrupt Controller

This block sits inside a power-management companion device and tells a host microcontroller about fault conditions. It watches four kinds of fault: supply undervoltage, supply overvoltage, a regulator over-temperature prewarning, and thermal overload on any of several high-side switches. It keeps a status word of live fault flags. When a fault appears it drives a fixed-width, active-low pulse on the interrupt pin. It also holds a single "interrupt happened" bit that the host collects with one status read. The host has no mask, so every fault that appears in run mode interrupts.

A thermal overload on a switch makes the block command that one switch off for as long as the overload lasts. Fault detection runs only in run mode. In stop mode the same interrupt pin instead reports rising wake events on the local wake inputs and the bus line. In sleep mode and in the idle/start-up state, nothing raises an interrupt.

All condition inputs are asynchronous. Each one passes through a two-flop synchronizer before the block looks for a rising edge.

Top module: `fault_irq_ctrl`

## Requirements
- R1: Mode input encoding: 2'b01 is run, 2'b10 is stop, 2'b11 is sleep, and 2'b00 is idle/start-up. In run mode there are four fault sources: undervoltage, overvoltage, temperature prewarning, and per-switch thermal overload.
- R2: No source can be masked. Any single fault source that rises alone in run mode produces an interrupt pulse.
- R3: The interrupt output `irq_no` is active low. A pulse lasts exactly PULSE_W (default 4) clock cycles. It goes low on the clock edge after the edge at which the synchronized condition rises.
- R4: The status flags follow the live, gated condition and do not latch. Status bit 0 is undervoltage, bit 1 is overvoltage, bit 2 is prewarning, and bit 3 is the OR of all switch overload flags.
- R5: Status bit 4 is the interrupt-source bit. Any interrupt sets it. It clears on the edge that ends a cycle in which `rd_stb_i` is high.
- R6: A thermal overload on switch k drives `hs_off_o[k]` high and leaves the other switches' off commands unaffected.
- R7: In stop, sleep and idle modes, status bits 3..0 and `hs_off_o` read zero, and faults raise no interrupt.
- R8: In stop mode, a rising edge on any wake input sets the source bit and produces an interrupt pulse.
- R9: Interrupts fire on rising edges, not levels. A condition that stays present gives one pulse only. A new event during a pulse restarts the full width.
- R10: Each condition input reaches the status word two clock edges after it changes.
- R11: If an event arrives in the same cycle as a status read, the source bit stays set.
- R12: Wake inputs have no effect outside stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Operating mode (encoding as in R1) |
| uv_i | input | 1 | Undervoltage comparator, asynchronous |
| ov_i | input | 1 | Overvoltage comparator, asynchronous |
| tpre_i | input | 1 | Regulator temperature prewarning, asynchronous |
| hs_ot_i | input | NUM_SW | Per-switch thermal overload, asynchronous |
| wake_i | input | NUM_WAKE | Wake sources (two local inputs, bus line), asynchronous |
| rd_stb_i | input | 1 | Host status-read strobe, one cycle per read |
| irq_no | output | 1 | Interrupt pulse, active low |
| status_o | output | 5 | Status word: {source, switch overload, prewarning, overvoltage, undervoltage} |
| hs_off_o | output | NUM_SW | Per-switch shutdown commands |

## Verification
The assertions take for granted that `mode_i` and `rd_stb_i` are already synchronous to `clk_i`, and that a read strobe lasts a single cycle per read. They do not assume that condition inputs are quiet, because edges may arrive during a pulse or while a read is in progress. The stimulus therefore changes the mode and the strobe only at the falling clock edge, and holds the mode for long stretches. The random faults and wakes toggle freely, and directed cases line up an event with a read strobe and with a pulse that is still running.

// File: rtl/fault_irq_pkg.sv
package fault_irq_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_RUN   = 2'b01,
    MODE_STOP  = 2'b10,
    MODE_SLEEP = 2'b11
  } op_mode_e;

  typedef struct packed {
    logic src;
    logic hsst;
    logic tpre;
    logic ov;
    logic uv;
  } status_t;

  localparam int STATUS_W = $bits(status_t);
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= d_i[i];
        stab_q <= meta_q;
      end
    end
    assign q_o[i] = stab_q;
  end
endmodule

// File: rtl/irq_pulse.sv
module irq_pulse #(
  parameter int PULSE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic irq_no
);
  localparam int CNT_W = $clog2(PULSE_W + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (trig_i)            cnt_q <= CNT_W'(PULSE_W); // retrigger restarts width
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign irq_no = (cnt_q == '0);

  assert_trig_lowers_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> !irq_no);
  assert_fall_needs_trig_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> $past(trig_i));
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl
  import fault_irq_pkg::*;
#(
  parameter int NUM_SW   = 3,
  parameter int NUM_WAKE = 3,
  parameter int PULSE_W  = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          mode_i,
  input  logic                uv_i,
  input  logic                ov_i,
  input  logic                tpre_i,
  input  logic [NUM_SW-1:0]   hs_ot_i,
  input  logic [NUM_WAKE-1:0] wake_i,
  input  logic                rd_stb_i,
  output logic                irq_no,
  output logic [4:0]          status_o,
  output logic [NUM_SW-1:0]   hs_off_o
);
  localparam int FLT_W  = 3 + NUM_SW;
  localparam int SYNC_W = FLT_W + NUM_WAKE;

  logic [SYNC_W-1:0]   raw, synced;
  logic [FLT_W-1:0]    flt_g, flt_q, flt_rise;
  logic [NUM_WAKE-1:0] wk_g, wk_q, wk_rise;
  logic                run, stop, any_evt, src_q;
  status_t             st;

  assign raw = {wake_i, hs_ot_i, tpre_i, ov_i, uv_i};

  fault_sync #(.W(SYNC_W)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (synced)
  );

  assign run  = (op_mode_e'(mode_i) == MODE_RUN);
  assign stop = (op_mode_e'(mode_i) == MODE_STOP);

  // detection gated by mode; flags are live, not latched
  assign flt_g = run  ? synced[FLT_W-1:0]      : '0;
  assign wk_g  = stop ? synced[SYNC_W-1:FLT_W] : '0;

  assign flt_rise = flt_g & ~flt_q;
  assign wk_rise  = wk_g  & ~wk_q;
  assign any_evt  = (|flt_rise) | (|wk_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flt_q <= '0;
      wk_q  <= '0;
      src_q <= 1'b0;
    end else begin
      flt_q <= flt_g;
      wk_q  <= wk_g;
      // new event wins over a coinciding read
      if (any_evt)       src_q <= 1'b1;
      else if (rd_stb_i) src_q <= 1'b0;
    end
  end

  irq_pulse #(.PULSE_W(PULSE_W)) i_pulse (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .trig_i(any_evt),
    .irq_no(irq_no)
  );

  always_comb begin
    st.uv   = flt_g[0];
    st.ov   = flt_g[1];
    st.tpre = flt_g[2];
    st.hsst = |flt_g[FLT_W-1:3];
    st.src  = src_q;
  end

  assign status_o = st;
  assign hs_off_o = flt_g[FLT_W-1:3];

  assert_src_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_evt |=> status_o[4]);
  assert_src_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !any_evt) |=> !status_o[4]);
  assert_hs_off_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hs_off_o) |-> status_o[3]);
  assert_quiet_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (status_o[3:0] == 4'b0 && hs_off_o == '0));
  assert_no_irq_lowpower_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> $past(run || stop));
endmodule

// File: tb/test_fault_irq_ctrl.sv
module test_fault_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSW = 3;
  localparam int NWK = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] in_mode = 2'b00;
  logic in_uv = 0, in_ov = 0, in_tpre = 0, in_rd = 0;
  logic [NSW-1:0] in_hs = '0;
  logic [NWK-1:0] in_wake = '0;
  logic irq_n;
  logic [4:0] status;
  logic [NSW-1:0] hs_off;

  int n_tests = 0, n_fail = 0;

  // bench reference state
  logic [8:0] m_s1 = '0, m_s2 = '0;
  logic [5:0] m_fq = '0;
  logic [2:0] m_wq = '0;
  int m_cnt = 0;
  bit m_src = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_irq_ctrl #(.NUM_SW(NSW), .NUM_WAKE(NWK), .PULSE_W(4)) i_fault_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(in_mode), .uv_i(in_uv), .ov_i(in_ov),
    .tpre_i(in_tpre), .hs_ot_i(in_hs), .wake_i(in_wake), .rd_stb_i(in_rd),
    .irq_no(irq_n), .status_o(status), .hs_off_o(hs_off)
  );

  function automatic logic [5:0] exp_flt();
    return (in_mode == 2'b01) ? m_s2[5:0] : 6'b0;
  endfunction

  function automatic logic [2:0] exp_wk();
    return (in_mode == 2'b10) ? m_s2[8:6] : 3'b0;
  endfunction

  function automatic logic [4:0] exp_status();
    logic [5:0] f = exp_flt();
    return {m_src, |f[5:3], f[2], f[1], f[0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [5:0] fg = exp_flt();
    logic [2:0] wg = exp_wk();
    bit ev = (|(fg & ~m_fq)) || (|(wg & ~m_wq));
    m_src = ev ? 1'b1 : (in_rd ? 1'b0 : m_src);
    m_cnt = ev ? 4 : (m_cnt > 0 ? m_cnt - 1 : 0);
    m_fq = fg;
    m_wq = wg;
    m_s2 = m_s1;
    m_s1 = {in_wake, in_hs, in_tpre, in_ov, in_uv};
  endtask

  // one clock: advance reference at posedge, compare at negedge
  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_edge();
    @(negedge clk);
    chk(irq_n == (m_cnt == 0), "R3 irq width/timing", irq_n, (m_cnt == 0));
    chk(status[3:0] == exp_status()[3:0], "R4 live flags", status, exp_status());
    chk(status[4] == m_src, "R5 source bit", status[4], m_src);
    chk(hs_off == exp_flt()[5:3], "R6 switch off", hs_off, exp_flt()[5:3]);
  endtask

  task automatic quiet();
    in_uv = 0; in_ov = 0; in_tpre = 0; in_hs = '0; in_wake = '0; in_rd = 0;
  endtask

  task automatic run_n(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      in_rd = 0;
      if (!irq_n) lows++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lows;
    void'($urandom(32'd7741));
    @(negedge clk);
    @(negedge clk);
    chk(irq_n == 1'b1, "R3 reset irq idle", irq_n, 1);
    chk(status == 5'b0, "R4 reset status", status, 0);
    chk(hs_off == '0, "R6 reset hs_off", hs_off, 0);
    rst_n = 1'b1;
    in_mode = 2'b01;
    run_n(5, lows);

    // R1 R2: each source alone interrupts, no mask exists
    for (int s = 0; s < 6; s++) begin
      quiet();
      case (s)
        0: in_uv = 1;
        1: in_ov = 1;
        2: in_tpre = 1;
        default: in_hs[s-3] = 1;
      endcase
      run_n(12, lows);
      chk(lows == 4, "R1 R2 source interrupts", lows, 4);
      quiet();
      run_n(4, lows);
    end

    // R6: single switch off only
    in_hs = 3'b010;
    run_n(3, lows);
    chk(hs_off == 3'b010, "R6 only switch 1 off", hs_off, 3'b010);
    quiet();
    run_n(8, lows);

    // R10: two-edge latency
    in_ov = 1;
    cyc();
    chk(status[1] == 1'b0, "R10 one edge not yet", status[1], 0);
    cyc();
    chk(status[1] == 1'b1, "R10 two edges visible", status[1], 1);
    // R9: level held gives one pulse
    run_n(20, lows);
    chk(lows == 4, "R9 held level one pulse", lows, 4);
    // R5: read clears
    in_rd = 1;
    cyc();
    in_rd = 0;
    cyc();
    chk(status[4] == 1'b0, "R5 cleared after read", status[4], 0);
    // R4: flag drops with condition
    in_ov = 0;
    run_n(3, lows);
    chk(status[1] == 1'b0, "R4 flag follows live", status[1], 0);

    // R9: retrigger during pulse restarts width
    in_uv = 1;
    run_n(4, lows);
    in_tpre = 1;
    run_n(12, lows);
    chk(lows == 6, "R9 retrigger restarts", lows, 6);
    quiet();
    in_rd = 1;
    run_n(6, lows);

    // R11: event coinciding with read
    in_uv = 1;
    cyc();
    cyc();
    in_rd = 1;
    cyc();
    in_rd = 0;
    chk(status[4] == 1'b1, "R11 source kept", status[4], 1);
    quiet();
    run_n(6, lows);

    // R12: wake ignored in run
    in_rd = 1;
    cyc();
    in_rd = 0;
    in_wake = 3'b100;
    run_n(10, lows);
    chk(lows == 0 && status[4] == 0, "R12 wake ignored in run", {lows, status[4]}, 0);
    quiet();

    // R7: sleep blocks faults
    in_mode = 2'b11;
    in_uv = 1; in_ov = 1; in_hs = 3'b111;
    run_n(10, lows);
    chk(lows == 0 && status[3:0] == 0, "R7 sleep quiet", {lows, status}, 0);
    quiet();
    run_n(4, lows);

    // R8: stop wake reports
    in_mode = 2'b10;
    run_n(3, lows);
    in_wake = 3'b001;
    run_n(10, lows);
    chk(lows == 4 && status[4] == 1, "R8 stop wake irq", {lows, status[4]}, {4, 1'b1});
    in_hs = 3'b001;
    run_n(6, lows);
    chk(lows == 0 && hs_off == 0, "R7 stop no fault", {lows, hs_off}, 0);
    quiet();
    run_n(4, lows);

    // random phase
    in_mode = 2'b01;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 59) == 0) in_mode = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) in_uv = ~in_uv;
      if ($urandom_range(0, 9) == 0) in_ov = ~in_ov;
      if ($urandom_range(0, 9) == 0) in_tpre = ~in_tpre;
      if ($urandom_range(0, 7) == 0) in_hs = in_hs ^ (3'b1 << $urandom_range(0, 2));
      if ($urandom_range(0, 7) == 0) in_wake = in_wake ^ (3'b1 << $urandom_range(0, 2));
      in_rd = ($urandom_range(0, 3) == 0);
      cyc();
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule